// File: doc/BRIEF.md
# Per-Instruction Delta-Correlating Prefetch Engine

This block is a second-level cache prefetch engine that learns, for each load or store instruction, the sequence of block-address strides it produces. It accepts training events, which are L2 misses and first touches of blocks that were brought in by a prefetch. Each event carries the instruction address (PC) and the block address. A per-instruction history table keeps a tag, the last block address, the two most recent deltas and a 2-bit confidence counter. A delta table shared by all instructions is indexed by a pair of deltas and returns the delta that followed that pair the last time it was seen.

Each accepted event runs three steps in order. The first step updates the entry. The second step predicts from the new history. The third step, when the confidence is high enough, chains further predictions. To chain, it shifts each predicted delta into a speculative copy of the history and looks up the delta table again. This issues up to `cfg_degree` prefetch block addresses, one per cycle. Training enters on a valid/ready stream and prefetches leave on a valid/ready stream. While a chain is in progress the engine takes no new training event. A stalled prefetch output holds its address until it is taken. The tables are register arrays kept inside the block.

Top module: `delta_prefetch_engine`

## Requirements
- R1: After reset, `in_ready` is 1, `pf_valid` is 0, every history entry is invalid and every delta-table entry is zero, so the first event for any PC issues no prefetch.
- R2: A training event is taken on a cycle with `in_valid` and `in_ready` both high. `in_ready` stays low from the cycle after a prefetch chain starts until the chain ends, and it is low whenever `pf_valid` is high.
- R3: The history entry is selected by `in_pc[3:0]` and tagged with `in_pc[15:4]`. On an invalid entry or a tag mismatch, the entry is rewritten with the new tag, the event address, both history deltas set to 0 and confidence 0. No prefetch follows, and `in_ready` is high again on the next cycle.
- R4: On a tag hit, the actual delta is the low 8 bits of (`in_addr` minus the stored last address), read as two's complement. It is compared with the delta-table value for the stored history. The confidence counter rises by 1 on a match, saturating at 3, and falls by 1 otherwise, saturating at 0.
- R5: On every tag hit, the delta-table entry for the stored (old) history is overwritten with the actual delta.
- R6: The delta-table index is {older delta bits [2:0], newer delta bits [2:0]}. After a hit, the entry's history becomes (older = previous newer, newer = actual delta) and its last address becomes `in_addr`.
- R7: A chain starts only on a hit where the updated confidence is 2 or more and `cfg_degree` is not 0. `cfg_degree` is sampled when the event is taken.
- R8: The first prefetch is `in_addr` plus the sign-extended delta-table value for the new history. Each later prefetch adds the value for the speculative history to the previous prefetch address, where each issued delta is shifted in as the newer delta. The delta table is read after the update of R5 has been written.
- R9: A chain issues at most `cfg_degree` prefetches. It ends at once, without issuing, when the looked-up delta is 0.
- R10: While `pf_valid` is 1 and `pf_ready` is 0, `pf_valid` stays 1 and `pf_addr` keeps its value on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Training event present |
| in_ready | output | 1 | Engine can take a training event |
| in_pc | input | 16 | Instruction address of the event |
| in_addr | input | 32 | Block address of the event |
| cfg_degree | input | 3 | Maximum prefetches per event (0 disables) |
| pf_valid | output | 1 | Prefetch address present |
| pf_ready | input | 1 | Consumer takes the prefetch |
| pf_addr | output | 32 | Prefetch block address |

## Verification
The bench starts with directed cases. A stride stream has to climb through the confidence threshold: an engine that prefetched early, or that compared against the delta table after writing it, would issue on the wrong event. Degree zero and degree limits catch chains that overrun, and a chain that runs into an untrained delta pair catches an engine that issues a zero-delta copy of the last address. Aliasing PCs on one entry, negative strides and the 2-2-6 repeating pattern check reallocation, sign extension and history shifting. Random stimulus with random output stalls checks that addresses are neither skipped nor repeated under back-pressure.

// File: rtl/dpe_pkg.sv
package dpe_pkg;
  localparam int CONF_W   = 2;
  localparam int CONF_MAX = 3;
  localparam int CONF_ON  = 2;

  function automatic logic [CONF_W-1:0] conf_next(input logic [CONF_W-1:0] c, input logic match);
    if (match) return (c == CONF_W'(CONF_MAX)) ? c : c + 1'b1;
    else       return (c == '0) ? c : c - 1'b1;
  endfunction
endpackage

// File: rtl/dpe_history_table.sv
module dpe_history_table #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 12,
  parameter int ADDR_W  = 32,
  parameter int DELTA_W = 8,
  parameter int CONF_W  = 2,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               rd_valid,
  output logic [TAG_W-1:0]   rd_tag,
  output logic [ADDR_W-1:0]  rd_last,
  output logic [DELTA_W-1:0] rd_older,
  output logic [DELTA_W-1:0] rd_newer,
  output logic [CONF_W-1:0]  rd_conf,
  input  logic               we,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [ADDR_W-1:0]  wr_last,
  input  logic [DELTA_W-1:0] wr_older,
  input  logic [DELTA_W-1:0] wr_newer,
  input  logic [CONF_W-1:0]  wr_conf
);
  logic               val_q   [ENTRIES];
  logic [TAG_W-1:0]   tag_q   [ENTRIES];
  logic [ADDR_W-1:0]  last_q  [ENTRIES];
  logic [DELTA_W-1:0] older_q [ENTRIES];
  logic [DELTA_W-1:0] newer_q [ENTRIES];
  logic [CONF_W-1:0]  conf_q  [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        val_q[i]   <= 1'b0;
        tag_q[i]   <= '0;
        last_q[i]  <= '0;
        older_q[i] <= '0;
        newer_q[i] <= '0;
        conf_q[i]  <= '0;
      end
    end else if (we) begin
      val_q[wr_idx]   <= 1'b1;
      tag_q[wr_idx]   <= wr_tag;
      last_q[wr_idx]  <= wr_last;
      older_q[wr_idx] <= wr_older;
      newer_q[wr_idx] <= wr_newer;
      conf_q[wr_idx]  <= wr_conf;
    end
  end

  assign rd_valid = val_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_last  = last_q[rd_idx];
  assign rd_older = older_q[rd_idx];
  assign rd_newer = newer_q[rd_idx];
  assign rd_conf  = conf_q[rd_idx];
endmodule

// File: rtl/dpe_delta_table.sv
module dpe_delta_table #(
  parameter int DELTA_W = 8,
  parameter int HASH_W  = 3,
  parameter int PORTS   = 2,
  localparam int IDX_W  = 2 * HASH_W,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [PORTS-1:0][DELTA_W-1:0]  rd_older,
  input  logic [PORTS-1:0][DELTA_W-1:0]  rd_newer,
  output logic [PORTS-1:0][DELTA_W-1:0]  rd_delta,
  input  logic                           we,
  input  logic [DELTA_W-1:0]             wr_older,
  input  logic [DELTA_W-1:0]             wr_newer,
  input  logic [DELTA_W-1:0]             wr_delta
);
  logic [DELTA_W-1:0] mem_q [ENTRIES];
  logic [IDX_W-1:0]   wr_idx;

  assign wr_idx = {wr_older[HASH_W-1:0], wr_newer[HASH_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[wr_idx] <= wr_delta;
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_rd
    logic [IDX_W-1:0] idx;
    assign idx         = {rd_older[p][HASH_W-1:0], rd_newer[p][HASH_W-1:0]};
    assign rd_delta[p] = mem_q[idx];
  end
endmodule

// File: rtl/dpe_chain.sv
module dpe_chain #(
  parameter int ADDR_W  = 32,
  parameter int DELTA_W = 8,
  parameter int DEG_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  start_addr,
  input  logic [DELTA_W-1:0] start_older,
  input  logic [DELTA_W-1:0] start_newer,
  input  logic [DEG_W-1:0]   start_degree,
  output logic [DELTA_W-1:0] spec_older,
  output logic [DELTA_W-1:0] spec_newer,
  input  logic [DELTA_W-1:0] dt_delta,
  output logic               busy,
  output logic               pf_valid,
  input  logic               pf_ready,
  output logic [ADDR_W-1:0]  pf_addr
);
  localparam int EXT_W = ADDR_W - DELTA_W;

  logic              busy_q;
  logic [ADDR_W-1:0] base_q;
  logic [DELTA_W-1:0] older_q, newer_q;
  logic [DEG_W-1:0]  left_q;
  logic              dead;

  assign dead       = (dt_delta == '0);
  assign busy       = busy_q;
  assign spec_older = older_q;
  assign spec_newer = newer_q;
  assign pf_valid   = busy_q && !dead;
  assign pf_addr    = base_q + {{EXT_W{dt_delta[DELTA_W-1]}}, dt_delta};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      base_q  <= '0;
      older_q <= '0;
      newer_q <= '0;
      left_q  <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      base_q  <= start_addr;
      older_q <= start_older;
      newer_q <= start_newer;
      left_q  <= start_degree;
    end else if (busy_q) begin
      if (dead) begin
        busy_q <= 1'b0;
      end else if (pf_ready) begin
        base_q  <= pf_addr;
        older_q <= newer_q;
        newer_q <= dt_delta;
        left_q  <= left_q - 1'b1;
        if (left_q == DEG_W'(1)) busy_q <= 1'b0;
      end
    end
  end

  assert_degree_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (left_q != '0));
endmodule

// File: rtl/delta_prefetch_engine.sv
module delta_prefetch_engine
  import dpe_pkg::*;
#(
  parameter int PC_W       = 16,
  parameter int ADDR_W     = 32,
  parameter int HT_ENTRIES = 16,
  parameter int DELTA_W    = 8,
  parameter int HASH_W     = 3,
  parameter int DEG_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PC_W-1:0]   in_pc,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DEG_W-1:0]  cfg_degree,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int HT_IDX_W = $clog2(HT_ENTRIES);
  localparam int TAG_W    = PC_W - HT_IDX_W;

  logic               take, hit, match, start, busy;
  logic [HT_IDX_W-1:0] idx;
  logic [TAG_W-1:0]   tag;
  logic               rd_valid;
  logic [TAG_W-1:0]   rd_tag;
  logic [ADDR_W-1:0]  rd_last, diff;
  logic [DELTA_W-1:0] rd_older, rd_newer, actual;
  logic [CONF_W-1:0]  rd_conf, new_conf;
  logic [DELTA_W-1:0] wr_older, wr_newer;
  logic [CONF_W-1:0]  wr_conf;
  logic [1:0][DELTA_W-1:0] dt_older, dt_newer, dt_out;
  logic [DELTA_W-1:0] spec_older, spec_newer;

  assign in_ready = !busy;
  assign take     = in_valid && in_ready;
  assign idx      = in_pc[HT_IDX_W-1:0];
  assign tag      = in_pc[PC_W-1:HT_IDX_W];
  assign hit      = rd_valid && (rd_tag == tag);
  assign diff     = in_addr - rd_last;
  assign actual   = diff[DELTA_W-1:0];

  // port 0: prediction made for the stored history; port 1: speculative chain
  assign dt_older[0] = rd_older;
  assign dt_newer[0] = rd_newer;
  assign dt_older[1] = spec_older;
  assign dt_newer[1] = spec_newer;

  assign match    = (dt_out[0] == actual);
  assign new_conf = conf_next(rd_conf, match);
  assign wr_older = hit ? rd_newer : '0;
  assign wr_newer = hit ? actual : '0;
  assign wr_conf  = hit ? new_conf : '0;
  assign start    = take && hit && (new_conf >= CONF_W'(CONF_ON)) && (cfg_degree != '0);

  dpe_history_table #(
    .ENTRIES(HT_ENTRIES), .TAG_W(TAG_W), .ADDR_W(ADDR_W),
    .DELTA_W(DELTA_W), .CONF_W(CONF_W)
  ) u_hist (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_last(rd_last),
    .rd_older(rd_older), .rd_newer(rd_newer), .rd_conf(rd_conf),
    .we(take), .wr_idx(idx), .wr_tag(tag), .wr_last(in_addr),
    .wr_older(wr_older), .wr_newer(wr_newer), .wr_conf(wr_conf)
  );

  dpe_delta_table #(.DELTA_W(DELTA_W), .HASH_W(HASH_W), .PORTS(2)) u_dt (
    .clk(clk), .rst_n(rst_n),
    .rd_older(dt_older), .rd_newer(dt_newer), .rd_delta(dt_out),
    .we(take && hit), .wr_older(rd_older), .wr_newer(rd_newer), .wr_delta(actual)
  );

  dpe_chain #(.ADDR_W(ADDR_W), .DELTA_W(DELTA_W), .DEG_W(DEG_W)) u_chain (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_addr(in_addr), .start_older(rd_newer),
    .start_newer(actual), .start_degree(cfg_degree),
    .spec_older(spec_older), .spec_newer(spec_newer), .dt_delta(dt_out[1]),
    .busy(busy), .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
  );

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));

  assert_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> !in_ready);

  assert_alloc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !hit) |=> (in_ready && !pf_valid));

  assert_lowconf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && hit && (new_conf < CONF_W'(CONF_ON))) |=> in_ready);
endmodule

// File: tb/sim_delta_prefetch_engine.sv
`timescale 1ns/1ps
module sim_delta_prefetch_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_pc = '0;
  logic [31:0] in_addr = '0;
  logic [2:0]  cfg_degree = '0;
  logic        pf_valid;
  logic        pf_ready = 1'b0;
  logic [31:0] pf_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  delta_prefetch_engine u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pc(in_pc), .in_addr(in_addr), .cfg_degree(cfg_degree),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
  );

  // reference model built from the requirements
  bit        m_val [16];
  bit [11:0] m_tag [16];
  bit [31:0] m_last[16];
  bit [7:0]  m_old [16];
  bit [7:0]  m_new [16];
  bit [1:0]  m_conf[16];
  bit [7:0]  m_dt  [64];
  bit [31:0] exp_q [8];
  int        exp_n;

  function automatic bit [5:0] dt_idx(input bit [7:0] o, input bit [7:0] n);
    return {o[2:0], n[2:0]};
  endfunction

  function automatic bit [31:0] sext(input bit [7:0] d);
    return {{24{d[7]}}, d};
  endfunction

  task automatic model_event(input bit [15:0] pc, input bit [31:0] a, input bit [2:0] deg);
    bit [3:0]  i = pc[3:0];
    bit [7:0]  act, pred, o, n, d;
    bit [31:0] p;
    exp_n = 0;
    if (m_val[i] && m_tag[i] == pc[15:4]) begin
      p    = a - m_last[i];
      act  = p[7:0];
      pred = m_dt[dt_idx(m_old[i], m_new[i])];
      if (pred == act) m_conf[i] = (m_conf[i] == 3) ? 2'd3 : m_conf[i] + 1;
      else             m_conf[i] = (m_conf[i] == 0) ? 2'd0 : m_conf[i] - 1;
      m_dt[dt_idx(m_old[i], m_new[i])] = act;
      m_old[i]  = m_new[i];
      m_new[i]  = act;
      m_last[i] = a;
      if (m_conf[i] >= 2 && deg != 0) begin
        o = m_old[i]; n = m_new[i]; p = a;
        for (int k = 0; k < int'(deg); k++) begin
          d = m_dt[dt_idx(o, n)];
          if (d == 0) break;
          p = p + sext(d);
          exp_q[exp_n] = p;
          exp_n++;
          o = n; n = d;
        end
      end
    end else begin
      m_val[i] = 1; m_tag[i] = pc[15:4]; m_last[i] = a;
      m_old[i] = 0; m_new[i] = 0; m_conf[i] = 0;
    end
  endtask

  task automatic check(input bit ok, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", what, got, exp);
    end
  endtask

  // one training event, then drain the resulting prefetches under random stalls
  task automatic train(input bit [15:0] pc, input bit [31:0] a, input bit [2:0] deg,
                       input string tagname, input int stall_pct);
    int got = 0;
    @(negedge clk);
    in_valid = 1; in_pc = pc; in_addr = a; cfg_degree = deg;
    model_event(pc, a, deg);
    @(posedge clk);
    #1 in_valid = 0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      pf_ready = (($urandom % 100) >= stall_pct);
      #1;
      if (in_ready) break;
      if (pf_valid && pf_ready) begin
        check(got < exp_n, {tagname, " R9 extra prefetch"}, pf_addr, 32'(exp_n));
        if (got < exp_n)
          check(pf_addr == exp_q[got], {tagname, " R8 prefetch address"}, pf_addr, exp_q[got]);
        got++;
      end
    end
    check(got == exp_n, {tagname, " R9 prefetch count"}, 32'(got), 32'(exp_n));
    check(in_ready && !pf_valid, {tagname, " R2 ready after chain"}, {30'd0, in_ready, pf_valid}, 32'd2);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(in_ready == 1 && pf_valid == 0, "R1 reset ready/valid", {30'd0, in_ready, pf_valid}, 32'd2);

    // R1 R3: first touch allocates, no prefetch
    train(16'h0012, 32'd20, 3'd4, "R1 first touch", 0);
    // R4 R5 R6 R7: confidence climbs over a +2 stride; prefetch begins only at conf 2
    for (int k = 1; k <= 6; k++) train(16'h0012, 32'(20 + 2 * k), 3'd4, "R7 stride climb", 30);
    // R7: degree zero gives no prefetch
    train(16'h0012, 32'd34, 3'd0, "R7 degree zero", 0);
    // R8 R9: degree limits, full and small
    train(16'h0012, 32'd36, 3'd7, "R9 degree 7", 50);
    train(16'h0012, 32'd38, 3'd1, "R9 degree 1", 0);
    // R6 R8: 2,2,6 repeating pattern on another instruction
    begin
      bit [31:0] a = 32'h1000;
      for (int k = 0; k < 15; k++) begin
        train(16'h0345, a, 3'd7, "R8 pattern 2-2-6", 40);
        a = a + ((k % 3 == 2) ? 32'd6 : 32'd2);
      end
    end
    // R3: alias on the same entry reallocates, old PC then misses too
    train(16'h0A12, 32'd500, 3'd4, "R3 alias realloc", 0);
    train(16'h0012, 32'd40, 3'd4, "R3 return after realloc", 0);
    // R4 R8: negative stride and sign extension
    for (int k = 0; k < 8; k++) train(16'h0777, 32'(32'h8000 - 3 * k), 3'd5, "R8 negative stride", 20);
    // R10: heavy stalls on an established chain
    train(16'h0777, 32'h8000 - 24, 3'd7, "R10 stalled chain", 85);

    // random traffic: few PCs, mixed strides with jumps
    begin
      bit [31:0] base [6];
      bit [31:0] str  [6];
      for (int p = 0; p < 6; p++) begin
        base[p] = $urandom;
        str[p]  = 32'($urandom % 9) - 32'd4;
      end
      for (int n = 0; n < 400; n++) begin
        int p = $urandom % 6;
        if ($urandom % 16 == 0) base[p] = $urandom;
        else base[p] = base[p] + (($urandom % 5 == 0) ? 32'd1 : str[p]);
        train({4'(p), 8'h5A, 4'(p * 3 % 16)}, base[p], 3'($urandom), "R4 random traffic", 35);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule